// File: doc/BRIEF.md
# IQ Sample Bus Deinterleaver

This block sits on the receive side of a baseband processor, behind the pad capture cells of a shared 12-bit sample bus. Each clock it takes the word latched on the rising clock edge and, in double-rate mode, also the word latched on the falling edge, together with the frame strobe level that came with each word. A rising transition of the frame strobe marks slot 0 of a slot group. From the slot position the block rebuilds complete I/Q pairs per receive channel and presents each pair as two signed 12-bit values with a one-clock valid strobe.

The group length follows the configuration. It is two slots (I, Q) when only one receive channel is enabled and neither the opposite direction nor the force bit asks for the wide format. Otherwise it is four slots: channel 1 in slots 0 and 1, channel 2 in slots 2 and 3. In a four-slot group, the pair that belongs to a disabled channel is discarded. A strobe that breaks the expected pattern raises a one-clock alignment error and the block realigns on the next rising transition.

The sample bus cannot be stalled, so the output side has no ready input and applies no back-pressure. A downstream consumer must accept every cycle in which a valid is high. Configuration inputs are expected to change only while reset is held.

Top module: `iqd_deinterleave`

## Requirements
- R1: Bus words are 12-bit two's complement values with bit 11 as the sign bit. They reach `chN_i`/`chN_q` bit-exact and are declared signed, so 0x7FF reads as +2047 and 0x800 reads as -2048.
- R2: With exactly one channel enabled (`cfg_ch_en` = 01 or 10), `cfg_peer_dual`=0 and `cfg_force_dual`=0, groups are two slots, I then Q. The pair goes to channel 1 when `cfg_ch_en[0]`=1, otherwise to channel 2.
- R3: With both channels enabled (`cfg_ch_en`=11), groups are four slots in the order I1, Q1, I2, Q2. The pair from slots 0-1 appears on channel 1 and the pair from slots 2-3 appears on channel 2.
- R4: When one channel is enabled but `cfg_peer_dual`=1, groups are four slots. The enabled channel takes its own slot pair, and the other pair is dropped with no valid on the disabled channel.
- R5: `cfg_force_dual`=1 makes a single-channel setup use four-slot groups, handled as in R4. With both channels enabled it changes nothing.
- R6: With `ddr_mode`=0, one word per clock is taken from `bus_word_r`/`bus_strobe_r`, and the falling-edge lane is ignored. With `ddr_mode`=1, two words per clock are taken, the rising-edge lane first and then the falling-edge lane. A group may start on either lane.
- R7: A low-to-high change of the strobe between consecutive taken words marks that word as slot 0. The strobe level in all other slots is free, but it must be low on the word before the next slot 0.
- R8: `align_err` pulses for one clock when a rising strobe arrives in the middle of a group; slot counting then restarts at that word. It also pulses when no rising strobe arrives at a group boundary; words are then discarded until the next rising strobe.
- R9: A channel's valid is high for one clock, in the cycle after the clock edge that took its Q word, and carries the I and Q of that same group. At most one channel's valid is high in any cycle.
- R10: After reset, no valid and no `align_err` is raised until a rising strobe has been seen.
- R11: While `rst` is high and in the first cycle after it, all valids, `align_err` and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ddr_mode | input | 1 | 1: take both lanes per clock; 0: rising-edge lane only |
| cfg_ch_en | input | 2 | Receive channel enables, bit 0 = channel 1, bit 1 = channel 2 |
| cfg_peer_dual | input | 2 - 1 | Opposite direction uses two channels (forces four-slot groups) |
| cfg_force_dual | input | 1 | Use four-slot groups in single-channel setups |
| bus_word_r | input | 12 | Word captured on the rising clock edge |
| bus_strobe_r | input | 1 | Frame strobe level captured with `bus_word_r` |
| bus_word_f | input | 12 | Word captured on the falling clock edge |
| bus_strobe_f | input | 1 | Frame strobe level captured with `bus_word_f` |
| ch1_valid | output | 1 | Channel 1 pair valid, one clock per pair |
| ch1_i | output | 12 | Channel 1 I sample, signed |
| ch1_q | output | 12 | Channel 1 Q sample, signed |
| ch2_valid | output | 1 | Channel 2 pair valid, one clock per pair |
| ch2_i | output | 12 | Channel 2 I sample, signed |
| ch2_q | output | 12 | Channel 2 Q sample, signed |
| align_err | output | 1 | One-clock pulse on a frame strobe pattern error |

## Verification
The bench goes after the slot-mapping corners of the block. It checks the disabled pair in mixed and forced configurations, where a design that ignored the enables would emit spurious pairs on the silent channel. It starts groups on the falling-edge lane in double-rate mode, where a design that assumed lane 0 always holds slot 0 would pair a Q with the wrong I. It also injects a rising strobe in mid-group and a missing rising strobe at a group boundary, which a design with a free-running slot counter would either miss or report at the wrong place. It also feeds words before the first strobe and random junk on the idle falling lane, either of which would yield pairs that nobody sent.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  // number of receive channels the slot map knows about
  localparam int IQD_NCH   = 2;
  // capture lanes per clock: rising-edge word, falling-edge word
  localparam int IQD_LANES = 2;

  // slot tracker carried from word to word
  typedef struct packed {
    logic       aligned;  // a rising strobe has placed slot 0
    logic [1:0] slot;     // slot index the next taken word will occupy
    logic       prev_s;   // strobe level of the previous taken word
  } iqd_track_t;
endpackage

// File: rtl/iqd_group_cfg.sv
module iqd_group_cfg (
  input  logic [1:0] ch_en,
  input  logic       peer_dual,
  input  logic       force_dual,
  output logic       four_slot,
  output logic       tgt2
);
  logic single_cfg;

  always_comb begin
    single_cfg = (ch_en != 2'b11) && !peer_dual;
    // force only matters when nothing else already picked four slots
    four_slot  = !single_cfg || force_dual;
    // in two-slot groups the pair goes to the one enabled channel
    tgt2       = !ch_en[0];
  end
endmodule

// File: rtl/iqd_slot_step.sv
module iqd_slot_step
  import iqd_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                           lane_on,
  input  logic                           four_slot,
  input  logic                           tgt2,
  input  logic [IQD_NCH-1:0]             ch_en,
  input  iqd_track_t                     trk_in,
  input  logic [W-1:0]                   word,
  input  logic                           strobe,
  input  logic [IQD_NCH-1:0][W-1:0]      hold_in,
  output iqd_track_t                     trk_out,
  output logic [IQD_NCH-1:0][W-1:0]      hold_out,
  output logic [IQD_NCH-1:0]             emit,
  output logic [IQD_NCH-1:0][W-1:0]      emit_i,
  output logic [IQD_NCH-1:0][W-1:0]      emit_q,
  output logic                           err
);
  logic       rise;
  logic       take;
  logic       ch;
  logic [1:0] cur;
  logic [1:0] last;

  always_comb begin
    rise     = strobe && !trk_in.prev_s;
    last     = four_slot ? 2'd3 : 2'd1;
    trk_out  = trk_in;
    hold_out = hold_in;
    emit     = '0;
    emit_i   = '0;
    emit_q   = '0;
    err      = 1'b0;
    take     = 1'b0;
    cur      = trk_in.slot;
    ch       = tgt2;
    if (lane_on) begin
      trk_out.prev_s = strobe;
      if (rise) begin
        // a rise is always slot 0; mid-group it is an error
        err             = trk_in.aligned && (trk_in.slot != 2'd0);
        cur             = 2'd0;
        take            = 1'b1;
        trk_out.aligned = 1'b1;
      end else if (trk_in.aligned && (trk_in.slot == 2'd0)) begin
        // group boundary without a rise: drop until the next rise
        err             = 1'b1;
        trk_out.aligned = 1'b0;
      end else if (trk_in.aligned) begin
        take = 1'b1;
      end

      if (take) begin
        ch = four_slot ? cur[1] : tgt2;
        if (!cur[0]) begin
          hold_out[ch] = word;
        end else if (ch_en[ch]) begin
          emit[ch]   = 1'b1;
          emit_i[ch] = hold_in[ch];
          emit_q[ch] = word;
        end
        trk_out.slot = (cur == last) ? 2'd0 : cur + 2'd1;
      end
    end
  end
endmodule

// File: rtl/iqd_pair_out.sv
module iqd_pair_out
  import iqd_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic [IQD_LANES-1:0][IQD_NCH-1:0]        emit,
  input  logic [IQD_LANES-1:0][IQD_NCH-1:0][W-1:0] ei,
  input  logic [IQD_LANES-1:0][IQD_NCH-1:0][W-1:0] eq,
  input  logic [IQD_LANES-1:0]                     err,
  output logic [IQD_NCH-1:0]                       vld,
  output logic [IQD_NCH-1:0][W-1:0]                oi,
  output logic [IQD_NCH-1:0][W-1:0]                oq,
  output logic                                     err_o
);
  for (genvar c = 0; c < IQD_NCH; c++) begin : g_ch
    logic         any;
    logic [W-1:0] pi;
    logic [W-1:0] pq;
    logic         v_q;
    logic [W-1:0] i_q;
    logic [W-1:0] q_q;

    always_comb begin
      any = 1'b0;
      pi  = i_q;
      pq  = q_q;
      for (int l = 0; l < IQD_LANES; l++) begin
        if (emit[l][c]) begin
          any = 1'b1;
          pi  = ei[l][c];
          pq  = eq[l][c];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        i_q <= '0;
        q_q <= '0;
      end else begin
        v_q <= any;
        if (any) begin
          i_q <= pi;
          q_q <= pq;
        end
      end
    end

    assign vld[c] = v_q;
    assign oi[c]  = i_q;
    assign oq[c]  = q_q;
  end

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= |err;
  end
endmodule

// File: rtl/iqd_deinterleave.sv
module iqd_deinterleave
  import iqd_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ddr_mode,
  input  logic [1:0]          cfg_ch_en,
  input  logic                cfg_peer_dual,
  input  logic                cfg_force_dual,
  input  logic [W-1:0]        bus_word_r,
  input  logic                bus_strobe_r,
  input  logic [W-1:0]        bus_word_f,
  input  logic                bus_strobe_f,
  output logic                ch1_valid,
  output logic signed [W-1:0] ch1_i,
  output logic signed [W-1:0] ch1_q,
  output logic                ch2_valid,
  output logic signed [W-1:0] ch2_i,
  output logic signed [W-1:0] ch2_q,
  output logic                align_err
);
  logic four_slot;
  logic tgt2;

  iqd_group_cfg u_cfg (
    .ch_en      (cfg_ch_en),
    .peer_dual  (cfg_peer_dual),
    .force_dual (cfg_force_dual),
    .four_slot  (four_slot),
    .tgt2       (tgt2)
  );

  // lane 0 = rising-edge word, lane 1 = falling-edge word
  logic [IQD_LANES-1:0][W-1:0] lane_word;
  logic [IQD_LANES-1:0]        lane_strobe;
  logic [IQD_LANES-1:0]        lane_on;

  assign lane_word   = {bus_word_f, bus_word_r};
  assign lane_strobe = {bus_strobe_f, bus_strobe_r};
  assign lane_on     = {ddr_mode, 1'b1};

  iqd_track_t                  trk_q;
  logic [IQD_NCH-1:0][W-1:0]   hold_q;

  iqd_track_t                  trk_c  [IQD_LANES+1];
  logic [IQD_NCH-1:0][W-1:0]   hold_c [IQD_LANES+1];

  logic [IQD_LANES-1:0][IQD_NCH-1:0]        emit_l;
  logic [IQD_LANES-1:0][IQD_NCH-1:0][W-1:0] ei_l;
  logic [IQD_LANES-1:0][IQD_NCH-1:0][W-1:0] eq_l;
  logic [IQD_LANES-1:0]                     err_l;

  assign trk_c[0]  = trk_q;
  assign hold_c[0] = hold_q;

  // words of one clock are walked in capture order through a chain of steps
  for (genvar l = 0; l < IQD_LANES; l++) begin : g_lane
    iqd_slot_step #(.W(W)) u_step (
      .lane_on   (lane_on[l]),
      .four_slot (four_slot),
      .tgt2      (tgt2),
      .ch_en     (cfg_ch_en),
      .trk_in    (trk_c[l]),
      .word      (lane_word[l]),
      .strobe    (lane_strobe[l]),
      .hold_in   (hold_c[l]),
      .trk_out   (trk_c[l+1]),
      .hold_out  (hold_c[l+1]),
      .emit      (emit_l[l]),
      .emit_i    (ei_l[l]),
      .emit_q    (eq_l[l]),
      .err       (err_l[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_q  <= '0;
      hold_q <= '0;
    end else begin
      trk_q  <= trk_c[IQD_LANES];
      hold_q <= hold_c[IQD_LANES];
    end
  end

  logic [IQD_NCH-1:0]        vld;
  logic [IQD_NCH-1:0][W-1:0] oi;
  logic [IQD_NCH-1:0][W-1:0] oq;

  iqd_pair_out #(.W(W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .emit  (emit_l),
    .ei    (ei_l),
    .eq    (eq_l),
    .err   (err_l),
    .vld   (vld),
    .oi    (oi),
    .oq    (oq),
    .err_o (align_err)
  );

  assign ch1_valid = vld[0];
  assign ch1_i     = oi[0];
  assign ch1_q     = oq[0];
  assign ch2_valid = vld[1];
  assign ch2_i     = oi[1];
  assign ch2_q     = oq[1];
endmodule

// File: rtl/iqd_checker.sv
module iqd_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         ddr_mode,
  input logic [1:0]   cfg_ch_en,
  input logic         bus_strobe_r,
  input logic         bus_strobe_f,
  input logic         ch1_valid,
  input logic         ch2_valid,
  input logic         align_err
);
  // any strobe high seen since reset (a rise needs one)
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= seen_q | bus_strobe_r | (ddr_mode & bus_strobe_f);
  end

  assert_no_early_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> (!ch1_valid && !ch2_valid && !align_err));

  assert_silent_ch1_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_ch_en[0]) |-> !ch1_valid);

  assert_silent_ch2_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_ch_en[1]) |-> !ch2_valid);

  assert_one_pair_per_clock_R9: assert property (@(posedge clk) disable iff (rst)
    !(ch1_valid && ch2_valid));

  assert_sdr_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (ch1_valid && !ddr_mode) |=> !ch1_valid);

  assert_err_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (align_err && !ddr_mode) |=> !align_err);
endmodule

bind iqd_deinterleave iqd_checker #(.W(W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .ddr_mode     (ddr_mode),
  .cfg_ch_en    (cfg_ch_en),
  .bus_strobe_r (bus_strobe_r),
  .bus_strobe_f (bus_strobe_f),
  .ch1_valid    (ch1_valid),
  .ch2_valid    (ch2_valid),
  .align_err    (align_err)
);

// File: tb/test_iqd_deinterleave.sv
module test_iqd_deinterleave;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ddr_mode = 1'b0;
  logic [1:0] cfg_ch_en = 2'b01;
  logic cfg_peer_dual = 1'b0;
  logic cfg_force_dual = 1'b0;
  logic [W-1:0] bus_word_r = '0;
  logic bus_strobe_r = 1'b0;
  logic [W-1:0] bus_word_f = '0;
  logic bus_strobe_f = 1'b0;
  logic ch1_valid, ch2_valid, align_err;
  logic signed [W-1:0] ch1_i, ch1_q, ch2_i, ch2_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  iqd_deinterleave #(.W(W)) i_iqd_deinterleave (
    .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .cfg_ch_en(cfg_ch_en),
    .cfg_peer_dual(cfg_peer_dual), .cfg_force_dual(cfg_force_dual),
    .bus_word_r(bus_word_r), .bus_strobe_r(bus_strobe_r),
    .bus_word_f(bus_word_f), .bus_strobe_f(bus_strobe_f),
    .ch1_valid(ch1_valid), .ch1_i(ch1_i), .ch1_q(ch1_q),
    .ch2_valid(ch2_valid), .ch2_i(ch2_i), .ch2_q(ch2_q),
    .align_err(align_err));

  int n_checks = 0;
  int n_errors = 0;
  int n_err_pulses = 0;
  int n_valid = 0;
  bit done = 1'b0;
  string cur_req = "R9";
  logic [W-1:0] last_i, last_q;

  logic [2*W-1:0] exp1[$];
  logic [2*W-1:0] exp2[$];
  logic [W-1:0]   sw[$];
  logic           ss[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // output monitor: every valid must match the next expected pair
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (ch1_valid) begin
        n_valid++;
        last_i = ch1_i;
        last_q = ch1_q;
        if (exp1.size() == 0) check(1'b0, cur_req, "unexpected ch1 pair", {ch1_i, ch1_q}, 0);
        else begin
          logic [2*W-1:0] e;
          e = exp1.pop_front();
          check({ch1_i, ch1_q} == e, cur_req, "ch1 pair", {ch1_i, ch1_q}, e);
        end
      end
      if (ch2_valid) begin
        n_valid++;
        if (exp2.size() == 0) check(1'b0, cur_req, "unexpected ch2 pair", {ch2_i, ch2_q}, 0);
        else begin
          logic [2*W-1:0] e;
          e = exp2.pop_front();
          check({ch2_i, ch2_q} == e, cur_req, "ch2 pair", {ch2_i, ch2_q}, e);
        end
      end
      if (align_err) n_err_pulses++;
    end
  end

  function automatic bit four_of(logic [1:0] en, bit peer, bit frc);
    return (en == 2'b11) || peer || frc;
  endfunction

  task automatic do_reset(bit ddr, logic [1:0] en, bit peer, bit frc);
    @(negedge clk);
    rst = 1'b1;
    ddr_mode = ddr; cfg_ch_en = en; cfg_peer_dual = peer; cfg_force_dual = frc;
    bus_word_r = '0; bus_strobe_r = 1'b0; bus_word_f = '0; bus_strobe_f = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp1.delete(); exp2.delete(); sw.delete(); ss.delete();
    n_err_pulses = 0;
    n_valid = 0;
  endtask

  task automatic add_word(logic [W-1:0] w, logic s);
    sw.push_back(w);
    ss.push_back(s);
  endtask

  task automatic add_pair_exp(int ch, logic [W-1:0] i, logic [W-1:0] q);
    if (ch == 0) exp1.push_back({i, q});
    else         exp2.push_back({i, q});
  endtask

  // one slot group; strobe high on slot 0 only
  task automatic add_group(logic [1:0] en, bit four);
    int npairs = four ? 2 : 1;
    for (int p = 0; p < npairs; p++) begin
      logic [W-1:0] i = W'($urandom);
      logic [W-1:0] q = W'($urandom);
      int ch = four ? p : (en[0] ? 0 : 1);
      add_word(i, p == 0);
      add_word(q, 1'b0);
      if (en[ch]) add_pair_exp(ch, i, q);
    end
  endtask

  task automatic drive_idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_word_r = W'($urandom); bus_strobe_r = 1'b0;
      bus_word_f = W'($urandom); bus_strobe_f = ddr_mode ? 1'b0 : 1'($urandom);
    end
  endtask

  task automatic feed();
    while (sw.size() > 0) begin
      @(negedge clk);
      bus_word_r = sw.pop_front(); bus_strobe_r = ss.pop_front();
      if (ddr_mode) begin
        if (sw.size() > 0) begin
          bus_word_f = sw.pop_front(); bus_strobe_f = ss.pop_front();
        end else begin
          bus_word_f = '0; bus_strobe_f = 1'b0;
        end
      end else begin
        // falling lane carries junk that must be ignored in single rate
        bus_word_f = W'($urandom); bus_strobe_f = 1'($urandom);
      end
    end
    drive_idle(3);
  endtask

  task automatic finish_run(string req, int exp_err);
    check(exp1.size() == 0, req, "ch1 pairs missing", exp1.size(), 0);
    check(exp2.size() == 0, req, "ch2 pairs missing", exp2.size(), 0);
    check(n_err_pulses == exp_err, "R8", "align_err pulse count", n_err_pulses, exp_err);
  endtask

  task automatic run_random(string req, bit ddr, logic [1:0] en, bit peer, bit frc,
                            int ngroups, int lead);
    do_reset(ddr, en, peer, frc);
    cur_req = req;
    for (int k = 0; k < lead; k++) add_word(W'($urandom), 1'b0);
    for (int g = 0; g < ngroups; g++) add_group(en, four_of(en, peer, frc));
    feed();
    // one error: first idle word after the last group lacks a rise
    finish_run(req, 1);
  endtask

  initial begin
    void'($urandom(32'h51ce));

    // R11 reset state
    do_reset(1'b0, 2'b01, 1'b0, 1'b0);
    check(ch1_valid == 0 && ch2_valid == 0, "R11", "valids after reset", {ch1_valid, ch2_valid}, 0);
    check(align_err == 0, "R11", "align_err after reset", align_err, 0);
    check(ch1_i == 0 && ch1_q == 0 && ch2_i == 0 && ch2_q == 0, "R11", "data after reset",
          {ch1_i, ch1_q}, 0);

    // R10 words with no strobe rise produce nothing
    cur_req = "R10";
    drive_idle(8);
    check(n_valid == 0, "R10", "valids before first rise", n_valid, 0);
    check(n_err_pulses == 0, "R10", "align_err before first rise", n_err_pulses, 0);

    // R1 extreme signed values
    do_reset(1'b0, 2'b01, 1'b0, 1'b0);
    cur_req = "R1";
    add_word(12'h7FF, 1'b1); add_word(12'h800, 1'b0);
    add_pair_exp(0, 12'h7FF, 12'h800);
    feed();
    check($signed(last_i) == 2047, "R1", "max positive I", int'($signed(last_i)), 2047);
    check($signed(last_q) == -2048, "R1", "max negative Q", int'($signed(last_q)), -2048);
    finish_run("R1", 1);

    // R2 two-slot groups, to channel 1 then to channel 2
    run_random("R2", 1'b0, 2'b01, 1'b0, 1'b0, 20, 0);
    run_random("R2", 1'b1, 2'b10, 1'b0, 1'b0, 20, 0);

    // R3 four-slot groups, single and double rate
    run_random("R3", 1'b0, 2'b11, 1'b0, 1'b0, 16, 0);
    run_random("R3", 1'b1, 2'b11, 1'b0, 1'b0, 16, 0);

    // R4 mixed configuration, unused pair dropped
    run_random("R4", 1'b0, 2'b01, 1'b1, 1'b0, 16, 0);
    run_random("R4", 1'b1, 2'b10, 1'b1, 1'b0, 16, 0);

    // R5 force bit: wide format for single, no change for dual
    run_random("R5", 1'b1, 2'b01, 1'b0, 1'b1, 16, 0);
    run_random("R5", 1'b0, 2'b11, 1'b0, 1'b1, 16, 0);

    // R6 / R7 groups starting on the falling-edge lane
    run_random("R6", 1'b1, 2'b11, 1'b0, 1'b0, 12, 1);
    run_random("R7", 1'b1, 2'b01, 1'b0, 1'b0, 12, 3);

    // R8 rise in mid-group: partial group then a full one
    do_reset(1'b0, 2'b11, 1'b0, 1'b0);
    cur_req = "R8";
    add_word(12'h101, 1'b1); add_word(12'h102, 1'b0);
    add_pair_exp(0, 12'h101, 12'h102);
    add_word(12'h201, 1'b1); add_word(12'h202, 1'b0);
    add_word(12'h203, 1'b0); add_word(12'h204, 1'b0);
    add_pair_exp(0, 12'h201, 12'h202);
    add_pair_exp(1, 12'h203, 12'h204);
    feed();
    finish_run("R8", 2);

    // R8 missing rise at a boundary: words dropped until next rise
    do_reset(1'b0, 2'b01, 1'b0, 1'b0);
    cur_req = "R8";
    add_word(12'h311, 1'b1); add_word(12'h312, 1'b0);
    add_pair_exp(0, 12'h311, 12'h312);
    add_word(12'h3AA, 1'b0); add_word(12'h3BB, 1'b0);
    add_word(12'h321, 1'b1); add_word(12'h322, 1'b0);
    add_pair_exp(0, 12'h321, 12'h322);
    feed();
    finish_run("R8", 2);

    // R9 double-rate two-slot stream gives a pair every clock
    run_random("R9", 1'b1, 2'b01, 1'b0, 1'b0, 24, 0);
    check(n_valid == 24, "R9", "pair count", n_valid, 24);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule